// File: doc/BRIEF.md
# Single-Carrier Multilevel Mask Modulator

This block drives the gates of one phase leg of a multilevel flying-capacitor converter with N_CELLS complementary switch pairs. It uses a single symmetric triangular carrier, built from an up/down counter. The rescaled reference from the upstream stage is compared with this carrier to give one raw PWM bit. The upstream stage also supplies the band that the reference currently occupies.

Each carrier slope lasts one interval, so a full mask cycle has 2·N_CELLS intervals. An interval pointer advances whenever the carrier changes direction. A constant mask table is addressed by band and interval and holds two bits per cell: a pass bit and a force bit. Each upper command is `(raw AND pass) OR force`. As a result, exactly one cell follows the raw PWM in any interval, and the other cells stay at fixed levels. Over the mask cycle the switching duty rotates across the cells, which keeps the flying capacitors naturally balanced.

The carrier runs as a two-state machine:
- RISE: the counter counts up. The transition RISE→FALL occurs on the edge where the carrier goes from CMAX−1 to CMAX.
- FALL: the counter counts down. The transition FALL→RISE occurs on the edge where the carrier goes from 1 to 0.

Both transitions advance the interval pointer.

The default table is derived at elaboration from N_CELLS, and it can be overridden through a parameter.

Top module: `lvl_mask_pwm`

## Requirements
- R1: While rst_n is low, every upper command is 0 and every lower command is 1. Reset leaves the carrier at 0, the state at RISE and the interval pointer at 1.
- R2: After reset, the carrier steps by exactly 1 on each clock edge.
  - It counts up 0,1,…,CMAX−1 in RISE, then enters FALL at CMAX.
  - It counts down CMAX,…,1 in FALL, then enters RISE at 0.
  - One carrier period is therefore 2·CMAX cycles.
- R3: The raw PWM bit is 1 exactly when ref_i is greater than the current carrier value, compared as unsigned numbers.
- R4: The interval pointer runs through 1..2·N_CELLS and advances on each RISE→FALL and FALL→RISE transition, wrapping from 2·N_CELLS to 1. Odd intervals are spent in RISE and even intervals in FALL.
- R5: Each upper command equals (raw AND pass bit) OR force bit for its cell, taken from the table entry of the current band and interval.
- R6: In any band and interval, at most one cell has its pass bit set. While band and interval are unchanged, only that cell's upper command may change.
- R7: The band code on band_i is the band number minus 1 (code 0 = lowest band). In the default table, with cells numbered 0..N_CELLS−1 and j = (interval+1)/2:
  - the cell that switches in odd interval 2j−1 is (j−1) mod N_CELLS, and it turns off;
  - the cell that switches in even interval 2j is (j+code) mod N_CELLS, and it turns on.
- R8: In the default table, a cell that is not switching is held at 1 if its most recent earlier switching interval (searching backward cyclically) was even, and held at 0 if it was odd.
- R9: sw_lo_o is always the bitwise complement of sw_hi_o.
- R10: With N_CELLS = 4 and band code 2, cell 0 behaves as follows:
  - it follows the raw PWM in intervals 1 and 4;
  - it is held at 0 in intervals 2 and 3;
  - it is held at 1 in intervals 5 to 8.
- R11: The number of upper commands at 1 depends only on the reference extremes:
  - it equals the band code when ref_i is 0;
  - it equals the band code plus 1 when ref_i exceeds CMAX.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; carrier and interval pointer step on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| band_i | input | BW | Band code of the reference (band number minus 1) |
| ref_i | input | CW | Rescaled reference, compared against the carrier |
| sw_hi_o | output | N_CELLS | Upper-switch commands, one per cell |
| sw_lo_o | output | N_CELLS | Lower-switch commands, complement of sw_hi_o |

## Verification
The carrier and interval pointer are registered, so a carrier step or interval change shows at the outputs one clock after the edge that causes it. band_i, ref_i and rst_n reach the outputs combinationally, within the same cycle.

The bench therefore drives inputs shortly after each rising edge and advances its own carrier and interval model on that same edge. It compares both output buses at the following falling edge, once everything has settled.

The toggle-isolation check compares consecutive falling-edge samples, but only when the band and interval are unchanged between them. Reset checks sample during reset itself, because the forced outputs apply at once.

// File: rtl/lvl_mask_pwm_pkg.sv
package lvl_mask_pwm_pkg;

    localparam int TBL_MAX = 2048;
    localparam int TBL_AW  = 11;

    typedef enum logic {S_RISE = 1'b0, S_FALL = 1'b1} slope_e;

    // Cell that switches in interval k (1-based) for band code bc.
    function automatic int switch_cell(int n, int bc, int k);
        int j;
        j = (k + 1) / 2;
        if ((k % 2) == 1) return (j - 1) % n;
        return (j + bc) % n;
    endfunction

    // Returns {pass, force} for cell c in band code bc, interval k.
    function automatic logic [1:0] mask_pair(int n, int bc, int k, int c);
        int kk;
        if (switch_cell(n, bc, k) == c) return 2'b10;
        for (int s = 1; s <= 2 * n; s++) begin
            kk = k - s;
            if (kk < 1) kk = kk + 2 * n;
            if (switch_cell(n, bc, kk) == c) return ((kk % 2) == 0) ? 2'b01 : 2'b00;
        end
        return 2'b00;
    endfunction

    function automatic logic [TBL_MAX-1:0] build_table(int n, bit pick_force);
        logic [TBL_MAX-1:0] t;
        logic [1:0]         p;
        int                 idx;
        t = '0;
        for (int b = 0; b < n; b++) begin
            for (int k = 1; k <= 2 * n; k++) begin
                for (int c = 0; c < n; c++) begin
                    idx = ((b * 2 * n) + (k - 1)) * n + c;
                    p   = mask_pair(n, b, k, c);
                    if (idx < TBL_MAX) t[idx[TBL_AW-1:0]] = pick_force ? p[0] : p[1];
                end
            end
        end
        return t;
    endfunction

endpackage

// File: rtl/lvl_carrier_fsm.sv
module lvl_carrier_fsm #(
    parameter int CMAX  = 9,
    parameter int N_INT = 8,
    parameter int CW    = 4,
    parameter int IW    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [CW-1:0] carrier_o,
    output logic [IW-1:0] ptr_o
);
    import lvl_mask_pwm_pkg::*;

    localparam logic [CW-1:0] TOP_M1 = CW'(CMAX - 1);
    localparam logic [CW-1:0] ONE    = CW'(1);
    localparam logic [IW-1:0] LAST   = IW'(N_INT);

    slope_e        state_q, state_d;
    logic [CW-1:0] car_q, car_d;
    logic [IW-1:0] ptr_q, ptr_d, ptr_next;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_RISE;
            car_q   <= '0;
            ptr_q   <= IW'(1);
        end else begin
            state_q <= state_d;
            car_q   <= car_d;
            ptr_q   <= ptr_d;
        end
    end

    assign ptr_next = (ptr_q == LAST) ? IW'(1) : ptr_q + 1'b1;

    always_comb begin
        state_d = state_q;
        car_d   = car_q;
        ptr_d   = ptr_q;
        unique case (state_q)
            S_RISE: begin
                car_d = car_q + 1'b1;
                if (car_q == TOP_M1) begin
                    state_d = S_FALL;
                    ptr_d   = ptr_next;
                end
            end
            S_FALL: begin
                car_d = car_q - 1'b1;
                if (car_q == ONE) begin
                    state_d = S_RISE;
                    ptr_d   = ptr_next;
                end
            end
        endcase
    end

    assign carrier_o = car_q;
    assign ptr_o     = ptr_q;

endmodule

// File: rtl/lvl_mask_rom.sv
module lvl_mask_rom #(
    parameter int N_CELLS  = 4,
    parameter int N_INT    = 8,
    parameter int BW       = 2,
    parameter int IW       = 4,
    parameter int TBL_BITS = 128,
    parameter logic [TBL_BITS-1:0] TBL_A = '0,
    parameter logic [TBL_BITS-1:0] TBL_B = '0
) (
    input  logic [BW-1:0]      band_i,
    input  logic [IW-1:0]      ptr_i,
    output logic [N_CELLS-1:0] mask_a_o,
    output logic [N_CELLS-1:0] mask_b_o
);
    localparam int AW = (TBL_BITS > 1) ? $clog2(TBL_BITS) : 1;

    logic [AW-1:0] base;

    assign base = AW'(int'(band_i) * N_INT * N_CELLS + (int'(ptr_i) - 1) * N_CELLS);

    for (genvar c = 0; c < N_CELLS; c++) begin : g_cell
        assign mask_a_o[c] = TBL_A[base + AW'(c)];
        assign mask_b_o[c] = TBL_B[base + AW'(c)];
    end

endmodule

// File: rtl/lvl_cell_gate.sv
module lvl_cell_gate (
    input  logic rst_n,
    input  logic raw_i,
    input  logic mask_a_i,
    input  logic mask_b_i,
    output logic hi_o,
    output logic lo_o
);
    always_comb begin
        if (!rst_n) hi_o = 1'b0;
        else        hi_o = (raw_i & mask_a_i) | mask_b_i;
    end

    assign lo_o = ~hi_o;

endmodule

// File: rtl/lvl_mask_pwm.sv
module lvl_mask_pwm #(
    parameter int N_CELLS  = 4,
    parameter int CMAX     = 9,
    parameter int N_INT    = 2 * N_CELLS,
    parameter int BW       = (N_CELLS > 1) ? $clog2(N_CELLS) : 1,
    parameter int CW       = $clog2(CMAX + 1),
    parameter int TBL_BITS = N_CELLS * N_INT * N_CELLS,
    parameter logic [TBL_BITS-1:0] MASK_A = TBL_BITS'(lvl_mask_pwm_pkg::build_table(N_CELLS, 1'b0)),
    parameter logic [TBL_BITS-1:0] MASK_B = TBL_BITS'(lvl_mask_pwm_pkg::build_table(N_CELLS, 1'b1))
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [BW-1:0]      band_i,
    input  logic [CW-1:0]      ref_i,
    output logic [N_CELLS-1:0] sw_hi_o,
    output logic [N_CELLS-1:0] sw_lo_o
);
    localparam int IW = $clog2(N_INT + 1);

    logic [CW-1:0]      carrier_w;
    logic [IW-1:0]      ptr_w;
    logic               raw_w;
    logic [N_CELLS-1:0] mask_a_w;
    logic [N_CELLS-1:0] mask_b_w;

    lvl_carrier_fsm #(.CMAX(CMAX), .N_INT(N_INT), .CW(CW), .IW(IW)) u_carrier (
        .clk       (clk),
        .rst_n     (rst_n),
        .carrier_o (carrier_w),
        .ptr_o     (ptr_w)
    );

    assign raw_w = ref_i > carrier_w;

    lvl_mask_rom #(
        .N_CELLS(N_CELLS), .N_INT(N_INT), .BW(BW), .IW(IW),
        .TBL_BITS(TBL_BITS), .TBL_A(MASK_A), .TBL_B(MASK_B)
    ) u_rom (
        .band_i   (band_i),
        .ptr_i    (ptr_w),
        .mask_a_o (mask_a_w),
        .mask_b_o (mask_b_w)
    );

    for (genvar c = 0; c < N_CELLS; c++) begin : g_gate
        lvl_cell_gate u_gate (
            .rst_n    (rst_n),
            .raw_i    (raw_w),
            .mask_a_i (mask_a_w[c]),
            .mask_b_i (mask_b_w[c]),
            .hi_o     (sw_hi_o[c]),
            .lo_o     (sw_lo_o[c])
        );
    end

endmodule

// File: rtl/lvl_mask_pwm_chk.sv
module lvl_mask_pwm_chk #(
    parameter int N_CELLS = 4,
    parameter int CMAX    = 9,
    parameter int BW      = 2,
    parameter int CW      = 4,
    parameter int IW      = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [CW-1:0]      carrier,
    input logic [IW-1:0]      ptr,
    input logic [N_CELLS-1:0] mask_a,
    input logic [BW-1:0]      band,
    input logic [N_CELLS-1:0] sw_hi,
    input logic [N_CELLS-1:0] sw_lo
);
    // R1
    p_reset_low_r1: assert property (@(posedge clk) !rst_n |-> sw_hi == '0);

    // R2
    p_carrier_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        int'(carrier) <= CMAX);

    // R2
    p_carrier_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (int'(carrier) == int'($past(carrier)) + 1 ||
                          int'(carrier) + 1 == int'($past(carrier))));

    // R4
    p_ptr_at_turn_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr != $past(ptr)) |-> (int'(carrier) == CMAX || carrier == '0));

    // R6
    p_pass_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mask_a));

    // R6
    p_only_pass_moves_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $stable(ptr) && $stable(band)) |->
            (((sw_hi ^ $past(sw_hi)) & ~mask_a) == '0));

    // R9
    p_lo_compl_r9: assert property (@(posedge clk) sw_lo == ~sw_hi);

endmodule

bind lvl_mask_pwm lvl_mask_pwm_chk #(
    .N_CELLS(N_CELLS), .CMAX(CMAX), .BW(BW), .CW(CW), .IW(IW)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .carrier (carrier_w),
    .ptr     (ptr_w),
    .mask_a  (mask_a_w),
    .band    (band_i),
    .sw_hi   (sw_hi_o),
    .sw_lo   (sw_lo_o)
);

// File: tb/lvl_mask_pwm_tb.sv
module lvl_mask_pwm_tb;
    localparam int N    = 4;
    localparam int CMAX = 9;
    localparam int NI   = 2 * N;
    localparam int BW   = 2;
    localparam int CW   = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [BW-1:0] band = '0;
    logic [CW-1:0] ref_v = '0;
    logic [N-1:0]  hi, lo;

    always #2 clk = ~clk;

    lvl_mask_pwm #(.N_CELLS(N), .CMAX(CMAX)) u_dut (
        .clk(clk), .rst_n(rst_n), .band_i(band), .ref_i(ref_v),
        .sw_hi_o(hi), .sw_lo_o(lo)
    );

    int checks = 0, fails = 0;
    bit done = 0;

    // behavioural carrier / interval model
    int car = 0, iv = 1;
    bit up  = 1;
    int prev_b = -1, prev_iv = -1;
    logic [N-1:0] prev_hi = '0;

    function automatic int sw_of(int bc, int k);
        int j = (k + 1) / 2;
        return (k % 2 == 1) ? (j - 1) % N : (j + bc) % N;
    endfunction

    function automatic logic [N-1:0] expect_hi(int bc, int k, int cv, int r);
        logic [N-1:0] e = '0;
        int kk;
        for (int c = 0; c < N; c++) begin
            if (sw_of(bc, k) == c) e[c] = (r > cv);
            else begin
                kk = k;
                do begin
                    kk = (kk == 1) ? NI : kk - 1;
                end while (sw_of(bc, kk) != c);
                e[c] = (kk % 2 == 0);
            end
        end
        return e;
    endfunction

    task automatic check(bit ok, string tag, int act, int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h (iv=%0d car=%0d)", tag, act, expv, iv, car);
        end
    endtask

    task automatic model_step();
        if (up) begin
            if (car == CMAX - 1) begin car = CMAX; up = 0; iv = (iv == NI) ? 1 : iv + 1; end
            else car++;
        end else begin
            if (car == 1) begin car = 0; up = 1; iv = (iv == NI) ? 1 : iv + 1; end
            else car--;
        end
    endtask

    task automatic cyc(int b, int r);
        logic [N-1:0] e;
        @(posedge clk);
        model_step();
        #1;
        band  = BW'(b);
        ref_v = CW'(r);
        @(negedge clk);
        e = expect_hi(b, iv, car, r);
        check(hi == e, "R2/R3/R4/R5/R7/R8 upper", int'(hi), int'(e));
        check(lo == ~e, "R9 lower", int'(lo), int'(~e));
        if (b == prev_b && iv == prev_iv)
            check($countones(hi ^ prev_hi) <= 1, "R6 toggles", $countones(hi ^ prev_hi), 1);
        prev_b = b; prev_iv = iv; prev_hi = hi;
    endtask

    initial begin
        repeat (3) begin
            @(negedge clk);
            check(hi == '0, "R1 reset upper", int'(hi), 0);
            check(lo == '1, "R1 reset lower", int'(lo), 15);
        end
        rst_n = 1'b1;
        check(hi == expect_hi(0, 1, 0, 0), "R1 start interval 1", int'(hi), int'(expect_hi(0, 1, 0, 0)));

        for (int b = 0; b < N; b++)
            for (int i = 0; i < 2 * NI * CMAX; i++)
                cyc(b, ((i / 3) * 5 + b) % 12);

        // R10: band code 2, cell 0 pattern
        for (int i = 0; i < NI * CMAX; i++) begin
            cyc(2, 5);
            if (iv == 2 || iv == 3)      check(hi[0] == 1'b0, "R10 cell0 held 0", int'(hi[0]), 0);
            else if (iv >= 5)            check(hi[0] == 1'b1, "R10 cell0 held 1", int'(hi[0]), 1);
            else                         check(hi[0] == (5 > car), "R10 cell0 follows", int'(hi[0]), int'(5 > car));
        end

        // R11: reference extremes
        for (int i = 0; i < NI * CMAX; i++) begin
            cyc(1, 0);
            check($countones(hi) == 1, "R11 ref zero", $countones(hi), 1);
        end
        for (int i = 0; i < NI * CMAX; i++) begin
            cyc(3, 15);
            check($countones(hi) == 4, "R11 ref above top", $countones(hi), 4);
        end

        // mid-run reset
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check(hi == '0, "R1 mid-run reset upper", int'(hi), 0);
        check(lo == '1, "R1 mid-run reset lower", int'(lo), 15);
        @(negedge clk);
        rst_n = 1'b1;
        car = 0; iv = 1; up = 1; prev_b = -1;
        for (int i = 0; i < 3 * CMAX; i++) cyc(2, 7);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog (all requirements) actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule